// File: doc/BRIEF.md
# Dual General-Purpose Port with Edge-Triggered Input Capture

This block provides two 8-bit general-purpose I/O ports, named A and B, behind a small register bus. Each port has an output register and a direction register with one bit per pin, and each has two control inputs. A host reads and writes the port registers through a 4-bit register address. The pins themselves are exported as separate input, output-value and output-enable vectors, so the pad ring builds the tri-state drivers.

Each control input passes through a synchroniser and then an edge detector whose active edge is chosen in the peripheral-control register. When input capture is enabled for a port, an active edge on that port's first control line stores the input pins in a capture register, and reads then return the captured value instead of the live pins. Every active edge also emits a one-cycle set pulse for an interrupt-flag bit. A host access to port A's main data address emits clear pulses for port A's flag bits. Port A also has a second, quiet data address that emits no clear pulses.

Every register access completes in the cycle it is presented. The bus has no wait states and no back-pressure, so it needs no valid/ready pair. Read data is combinational from the address.

Top module: `gpio_latch_port`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every output-enable bit, every output bit and every flag pulse is 0. The direction, aux-control and peripheral-control registers read back as 0x00.
- R2: The direction register of port B is at address 2 and that of port A is at address 3. After a write, the output-enable vector of that port equals the written byte from the next cycle on. A 1 bit makes the pin an output and a 0 bit makes it an input.
- R3: A write to address 0 loads the port B output register. A write to address 1 or address 15 loads the port A output register. The out vector of the port shows the value from the next cycle on.
- R4: A read of a data address (0 for B, 1 or 15 for A) returns the output-register bit for each output pin. For each input pin it returns the live pin value, or the captured value when capture is enabled.
- R5: The aux-control register is at address 11. Bit 0 enables capture for port A and bit 1 enables capture for port B. Its other bits always read as 0. Clearing the enable bit makes reads return live pins again.
- R6: Peripheral-control bit 0 selects the active edge of port A's first control line, and bit 4 does the same for port B (0 = falling, 1 = rising). Suppose the input changes before clock edge k. An active edge then raises set-pulse bit 1 (port A) or bit 4 (port B) for exactly the cycle between edges k+1 and k+2. An inactive edge raises nothing.
- R7: With capture enabled, the pins are sampled into the capture register at clock edge k+2 of an active first-line edge. The register holds that value until the next active edge, whatever the pins do in between.
- R8: The second control lines use peripheral-control bits 3:1 (port A) and 7:5 (port B). When bit 3 or bit 7 is 0 the line is an input. Bit 2 or bit 6 then picks its active edge (1 = rising), and an active edge raises set-pulse bit 0 (port A) or bit 3 (port B) with the R6 timing. When bit 3 or bit 7 is 1 the line raises no pulse.
- R9: A read or write at address 1 raises clear-pulse bits 1 and 0 in the same cycle. Bit 0 is left out while peripheral-control bit 1 is set. Accesses at address 15 or any other address raise no clear pulse.
- R10: The peripheral-control register at address 12 reads back as written. Addresses not listed above read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| ca1 | input | 1 | Port A first control line |
| ca2 | input | 1 | Port A second control line |
| cb1 | input | 1 | Port B first control line |
| cb2 | input | 1 | Port B second control line |
| irq_set | output | 8 | One-cycle flag set pulses (bits 0,1,3,4 used) |
| irq_clr | output | 8 | One-cycle flag clear pulses (bits 0,1 used) |

## Verification
A corrupted direction or output register appears on the enable or value vectors one cycle after the write. It also distorts the next data read through the bit mixing. A synchroniser or polarity fault moves, doubles or suppresses the set pulse, which is expected in exactly one cycle, two clocks after the line change. A capture register that loads at the wrong time returns a changed value on the first data read after the pins move. A bad clear-pulse decode shows in the same cycle as the access.

// File: rtl/gpio_latch_pkg.sv
package gpio_latch_pkg;
  localparam int FLAG_W = 8;

  // register addresses
  localparam logic [3:0] RA_DAT_B   = 4'd0;
  localparam logic [3:0] RA_DAT_A   = 4'd1;
  localparam logic [3:0] RA_DIR_B   = 4'd2;
  localparam logic [3:0] RA_DIR_A   = 4'd3;
  localparam logic [3:0] RA_AUX     = 4'd11;
  localparam logic [3:0] RA_PCTL    = 4'd12;
  localparam logic [3:0] RA_DAT_A_Q = 4'd15;

  // peripheral-control bit positions
  localparam int PC_A1_POL = 0;
  localparam int PC_A2_IND = 1;
  localparam int PC_A2_POL = 2;
  localparam int PC_A2_OUT = 3;
  localparam int PC_B1_POL = 4;
  localparam int PC_B2_POL = 6;
  localparam int PC_B2_OUT = 7;

  // flag bit positions
  localparam int FL_A2 = 0;
  localparam int FL_A1 = 1;
  localparam int FL_B2 = 3;
  localparam int FL_B1 = 4;

  // control line indices
  localparam int LN_A1 = 0;
  localparam int LN_A2 = 1;
  localparam int LN_B1 = 2;
  localparam int LN_B2 = 3;
  localparam int LN_N  = 4;
endpackage

// File: rtl/gpio_ctl_sync.sv
module gpio_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic rise_sel,
  output logic pulse_o
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              settled;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign settled = chain[STAGES-1];
  assign pulse_o = rise_sel ? (settled & ~prev) : (~settled & prev);

  // R6: an edge yields a single-cycle pulse
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_out,
  input  logic          wr_dir,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pins_i,
  input  logic          cap_i,
  input  logic          latch_en,
  output logic [DW-1:0] out_o,
  output logic [DW-1:0] oe_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] out_q, dir_q, cap_q;
  logic [DW-1:0] in_src;
  logic          take;

  assign take = cap_i & latch_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
      cap_q <= '0;
    end else begin
      if (wr_out) out_q <= wdata;
      if (wr_dir) dir_q <= wdata;
      if (take)   cap_q <= pins_i;
    end
  end

  assign in_src  = latch_en ? cap_q : pins_i;
  assign rdata_o = (out_q & dir_q) | (in_src & ~dir_q);
  assign out_o   = out_q;
  assign oe_o    = dir_q;

  // R7: the capture register only moves on a capture strobe
  p_cap_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_q) |-> $past(cap_i && latch_en));
  // R2: a direction write shows on the enables next cycle
  p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> oe_o == $past(wdata));
endmodule

// File: rtl/gpio_latch_port.sv
module gpio_latch_port
  import gpio_latch_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     pa_in,
  output logic [DW-1:0]     pa_out,
  output logic [DW-1:0]     pa_oe,
  input  logic [DW-1:0]     pb_in,
  output logic [DW-1:0]     pb_out,
  output logic [DW-1:0]     pb_oe,
  input  logic              ca1,
  input  logic              ca2,
  input  logic              cb1,
  input  logic              cb2,
  output logic [FLAG_W-1:0] irq_set,
  output logic [FLAG_W-1:0] irq_clr
);
  localparam logic [DW-1:0] AUX_MASK = DW'(3);

  logic          wr_en, acc_en, hit_a;
  logic [DW-1:0] aux_q, pctl_q;
  logic [DW-1:0] rd_a, rd_b;
  logic [LN_N-1:0] ln_raw, ln_pol, ln_pulse;

  assign wr_en  = bus_sel & bus_wr;
  assign acc_en = bus_sel & (bus_wr | bus_rd);
  assign hit_a  = acc_en & (bus_addr == RA_DAT_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_q  <= '0;
      pctl_q <= '0;
    end else if (wr_en) begin
      if (bus_addr == RA_AUX)  aux_q  <= bus_wdata & AUX_MASK;
      if (bus_addr == RA_PCTL) pctl_q <= bus_wdata;
    end
  end

  // control-line synchronisers and edge detectors
  assign ln_raw[LN_A1] = ca1;
  assign ln_raw[LN_A2] = ca2;
  assign ln_raw[LN_B1] = cb1;
  assign ln_raw[LN_B2] = cb2;
  assign ln_pol[LN_A1] = pctl_q[PC_A1_POL];
  assign ln_pol[LN_A2] = pctl_q[PC_A2_POL];
  assign ln_pol[LN_B1] = pctl_q[PC_B1_POL];
  assign ln_pol[LN_B2] = pctl_q[PC_B2_POL];

  for (genvar g = 0; g < LN_N; g++) begin : g_line
    gpio_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .pin_i    (ln_raw[g]),
      .rise_sel (ln_pol[g]),
      .pulse_o  (ln_pulse[g])
    );
  end

  always_comb begin
    irq_set        = '0;
    irq_set[FL_A1] = ln_pulse[LN_A1];
    irq_set[FL_A2] = ln_pulse[LN_A2] & ~pctl_q[PC_A2_OUT];
    irq_set[FL_B1] = ln_pulse[LN_B1];
    irq_set[FL_B2] = ln_pulse[LN_B2] & ~pctl_q[PC_B2_OUT];
    irq_clr        = '0;
    irq_clr[FL_A1] = hit_a;
    irq_clr[FL_A2] = hit_a & ~pctl_q[PC_A2_IND];
  end

  gpio_port_bank #(.DW(DW)) u_port_a (
    .clk      (clk),
    .rst      (rst),
    .wr_out   (wr_en & ((bus_addr == RA_DAT_A) | (bus_addr == RA_DAT_A_Q))),
    .wr_dir   (wr_en & (bus_addr == RA_DIR_A)),
    .wdata    (bus_wdata),
    .pins_i   (pa_in),
    .cap_i    (ln_pulse[LN_A1]),
    .latch_en (aux_q[0]),
    .out_o    (pa_out),
    .oe_o     (pa_oe),
    .rdata_o  (rd_a)
  );

  gpio_port_bank #(.DW(DW)) u_port_b (
    .clk      (clk),
    .rst      (rst),
    .wr_out   (wr_en & (bus_addr == RA_DAT_B)),
    .wr_dir   (wr_en & (bus_addr == RA_DIR_B)),
    .wdata    (bus_wdata),
    .pins_i   (pb_in),
    .cap_i    (ln_pulse[LN_B1]),
    .latch_en (aux_q[1]),
    .out_o    (pb_out),
    .oe_o     (pb_oe),
    .rdata_o  (rd_b)
  );

  always_comb begin
    case (bus_addr)
      RA_DAT_B:               bus_rdata = rd_b;
      RA_DAT_A, RA_DAT_A_Q:   bus_rdata = rd_a;
      RA_DIR_B:               bus_rdata = pb_oe;
      RA_DIR_A:               bus_rdata = pa_oe;
      RA_AUX:                 bus_rdata = aux_q;
      RA_PCTL:                bus_rdata = pctl_q;
      default:                bus_rdata = '0;
    endcase
  end

  // R1: everything idle right after reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pa_oe == '0 && pb_oe == '0 && irq_set == '0));
  // R3: port A output register follows a data write
  p_out_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_addr == RA_DAT_A_Q) |=> pa_out == $past(bus_wdata));
  // R9: the quiet alias never clears flags
  p_alias_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_en && bus_addr == RA_DAT_A_Q) |-> irq_clr == '0);
endmodule

// File: tb/sim_gpio_latch_port.sv
module sim_gpio_latch_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pa_in = 8'h5A, pb_in = 8'hC3;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, irq_set, irq_clr;
  logic       ca1 = 0, ca2 = 0, cb1 = 0, cb2 = 0;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  gpio_latch_port u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .ca1(ca1), .ca2(ca2), .cb1(cb1), .cb2(cb2),
    .irq_set(irq_set), .irq_clr(irq_clr)
  );

  typedef struct packed {
    logic       w;
    logic [3:0] a;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] req;
  } vec_t;

  // pins held at A=5A, B=C3 throughout the table
  localparam int NV = 22;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 4'd3,  8'h00, 8'h00, 4'd1},  // R1 dir A cleared
    '{1'b0, 4'd2,  8'h00, 8'h00, 4'd1},  // R1 dir B cleared
    '{1'b0, 4'd1,  8'h00, 8'h5A, 4'd4},  // R4 all inputs live
    '{1'b1, 4'd3,  8'hF0, 8'h00, 4'd2},
    '{1'b1, 4'd1,  8'hA5, 8'h00, 4'd3},
    '{1'b0, 4'd1,  8'h00, 8'hAA, 4'd4},  // R4 mixing
    '{1'b0, 4'd3,  8'h00, 8'hF0, 4'd2},  // R2 readback
    '{1'b1, 4'd15, 8'h3C, 8'h00, 4'd3},
    '{1'b0, 4'd15, 8'h00, 8'h3A, 4'd3},  // R3 alias write
    '{1'b1, 4'd2,  8'h0F, 8'h00, 4'd2},
    '{1'b1, 4'd0,  8'h66, 8'h00, 4'd3},
    '{1'b0, 4'd0,  8'h00, 8'hC6, 4'd4},  // R4 port B mixing
    '{1'b1, 4'd11, 8'hFF, 8'h00, 4'd5},
    '{1'b0, 4'd11, 8'h00, 8'h03, 4'd5},  // R5 upper bits zero
    '{1'b1, 4'd11, 8'h00, 8'h00, 4'd5},
    '{1'b1, 4'd12, 8'hA5, 8'h00, 4'd10},
    '{1'b0, 4'd12, 8'h00, 8'hA5, 4'd10}, // R10 pctl readback
    '{1'b1, 4'd12, 8'h00, 8'h00, 4'd10},
    '{1'b0, 4'd5,  8'h00, 8'h00, 4'd10}, // R10 unused reads 0
    '{1'b1, 4'd7,  8'hFF, 8'h00, 4'd10},
    '{1'b0, 4'd7,  8'h00, 8'h00, 4'd10},
    '{1'b0, 4'd3,  8'h00, 8'hF0, 4'd10}  // R10 no side effect
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [3:0] a, input logic [7:0] d,
                     output logic [7:0] rdv, output logic [7:0] clr);
    @(negedge clk);
    bus_sel = 1; bus_wr = w; bus_rd = !w; bus_addr = a; bus_wdata = d;
    #1;
    rdv = bus_rdata;
    clr = irq_clr;
    @(posedge clk);
    #1;
    bus_sel = 0; bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] r, c;
    acc(1'b1, a, d, r, c);
  endtask

  task automatic rchk(input logic [3:0] a, input logic [7:0] e, input string req);
    logic [7:0] r, c;
    acc(1'b0, a, 8'h00, r, c);
    chk(req, r, e);
  endtask

  // drive a control line at a falling edge, check pulse only two edges later
  task automatic edge_chk(input int ln, input logic lvl, input logic [7:0] e, input string req);
    @(negedge clk);
    case (ln)
      0: ca1 = lvl;
      1: ca2 = lvl;
      2: cb1 = lvl;
      default: cb2 = lvl;
    endcase
    @(negedge clk); chk(req, irq_set, 8'h00);
    @(negedge clk); chk(req, irq_set, e);
    @(negedge clk); chk(req, irq_set, 8'h00);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r, c;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 oe A in reset", pa_oe, 8'h00);
    rst = 0;
    @(negedge clk);
    chk("R1 oe A", pa_oe, 8'h00);
    chk("R1 oe B", pb_oe, 8'h00);
    chk("R1 out A", pa_out, 8'h00);
    chk("R1 set", irq_set, 8'h00);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].w, VEC[i].a, VEC[i].d, r, c);
      if (!VEC[i].w) chk($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].e);
    end
    chk("R2 oe A", pa_oe, 8'hF0);
    chk("R2 oe B", pb_oe, 8'h0F);
    chk("R3 out A", pa_out, 8'h3C);
    chk("R3 out B", pb_out, 8'h66);

    // first-line edges, port A
    wreg(4'd12, 8'h01);
    edge_chk(0, 1'b1, 8'h02, "R6 A1 rising");
    edge_chk(0, 1'b0, 8'h00, "R6 A1 falling ignored");

    // capture, port A
    wreg(4'd3, 8'h00);
    wreg(4'd11, 8'h01);
    pa_in = 8'h11;
    edge_chk(0, 1'b1, 8'h02, "R7 capture edge");
    pa_in = 8'h77;
    rchk(4'd1, 8'h11, "R7 holds captured");
    edge_chk(0, 1'b0, 8'h00, "R7 inactive edge");
    rchk(4'd1, 8'h11, "R7 no capture on inactive edge");
    pa_in = 8'h99;
    edge_chk(0, 1'b1, 8'h02, "R7 recapture");
    pa_in = 8'h22;
    rchk(4'd1, 8'h99, "R7 new capture");
    wreg(4'd11, 8'h00);
    rchk(4'd1, 8'h22, "R5 live after disable");

    wreg(4'd12, 8'h00);
    edge_chk(0, 1'b0, 8'h02, "R6 A1 falling active");

    // second lines
    wreg(4'd12, 8'h04);
    edge_chk(1, 1'b1, 8'h01, "R8 A2 rising");
    wreg(4'd12, 8'h0C);
    edge_chk(1, 1'b0, 8'h00, "R8 A2 output mode");
    edge_chk(1, 1'b1, 8'h00, "R8 A2 output mode rise");

    wreg(4'd12, 8'h10);
    edge_chk(2, 1'b1, 8'h10, "R6 B1 rising");
    wreg(4'd12, 8'h40);
    edge_chk(3, 1'b1, 8'h08, "R8 B2 rising");
    wreg(4'd12, 8'h00);
    edge_chk(2, 1'b0, 8'h10, "R6 B1 falling");

    // capture, port B
    wreg(4'd2, 8'h00);
    wreg(4'd11, 8'h02);
    wreg(4'd12, 8'h10);
    pb_in = 8'h3E;
    edge_chk(2, 1'b1, 8'h10, "R7 B capture edge");
    pb_in = 8'h00;
    rchk(4'd0, 8'h3E, "R7 B holds captured");

    // clear pulses
    wreg(4'd12, 8'h00);
    acc(1'b0, 4'd1, 8'h00, r, c);  chk("R9 read clears both", c, 8'h03);
    acc(1'b1, 4'd1, 8'h00, r, c);  chk("R9 write clears both", c, 8'h03);
    wreg(4'd12, 8'h02);
    acc(1'b0, 4'd1, 8'h00, r, c);  chk("R9 independent A2", c, 8'h02);
    acc(1'b0, 4'd15, 8'h00, r, c); chk("R9 alias quiet", c, 8'h00);
    acc(1'b0, 4'd0, 8'h00, r, c);  chk("R9 port B no clear", c, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule